// File: doc/BRIEF.md
# Asynchronous DRAM Controller with CAS-before-RAS Refresh

The block connects a simple single-beat request port to the pins of an asynchronous DRAM that has a multiplexed address bus. A request carries a write flag, a 16-bit address and 16-bit write data, and it is accepted when `req_valid` and `req_ready` are both high at a clock edge. The controller splits the address into an 8-bit row, the upper byte, and an 8-bit column, the lower byte. It places the two halves on the shared address pins one after the other and sequences the row strobe, column strobe, write enable and output enable. Read data comes back as a one-cycle `rsp_valid` pulse. Every minimum interval is a parameter counted in clock cycles.

A refresh timer raises a refresh request every `floor(WINDOW_MS*CLK_KHZ/ROWS)` cycles, which is 781 cycles at 50 MHz. This gives 256 refreshes in every 4 ms. A pending refresh is taken ahead of any waiting request, but it never cuts short an access that has already started. The refresh is of the CAS-before-RAS kind, so it carries no address and moves no data.

The sequencer has eight states, each with a down-counter loaded on entry. The transitions are:
- IDLE→CBR_CAS when a refresh is pending.
- IDLE→ROW when a request is accepted.
- ROW→COL, COL→ACCESS, ACCESS→PRECHARGE and PRECHARGE→IDLE.
- CBR_CAS→CBR_RAS, CBR_RAS→CBR_PRE and CBR_PRE→IDLE.

Each of these later transitions happens when the counter of the current state reaches zero. The access length is `ACC = max(T_CAC, T_CAA-T_ASC, T_RAC-T_RCD-T_ASC, T_RAS-T_RCD-T_ASC, 1)`.

Top module: `dram_ctrl`

## Requirements
- R1: At every access, the row address pins carry `req_addr[15:8]` when RAS_n falls. They carry `req_addr[7:0]` when CAS_n falls, and they hold that column value steady for as long as CAS_n stays low.
- R2: During a read, WE_n stays high. `rsp_valid` is high for exactly one cycle, in the cycle that starts `T_RCD+T_ASC+ACC` rising edges after the accepting edge, and `rsp_rdata` then holds the word last written to that address.
- R3: During a write, WE_n is low and `dram_dq_oe` is high with the write data on `dram_dq_out` before CAS_n falls, and OE_n stays high.
- R4: Each time RAS_n goes low, it stays low for at least `T_RAS` cycles.
- R5: Before each RAS_n falling edge, RAS_n has been high for at least `T_RP` cycles.
- R6: A refresh lowers CAS_n at least `T_CSR` cycles before RAS_n. While it runs, `dram_dq_oe` is low and OE_n and WE_n are high.
- R7: In any window of `WINDOW_MS*CLK_KHZ` cycles, at least `ROWS` refreshes begin.
- R8: `req_ready` is low for the whole refresh, and no refresh starts while RAS_n is low for an access.
- R9: After reset, RAS_n and CAS_n are high, `dram_dq_oe` and `rsp_valid` are low, and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address: row in the upper byte, column in the lower byte |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read data valid, one-cycle pulse |
| rsp_rdata | output | 16 | Read data |
| dram_addr | output | 8 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe |
| dram_cas_n | output | 1 | Column strobe |
| dram_we_n | output | 1 | Write enable |
| dram_oe_n | output | 1 | Output enable |
| dram_dq_out | output | 16 | Data driven to the memory |
| dram_dq_oe | output | 1 | Drive enable for `dram_dq_out` |
| dram_dq_in | input | 16 | Data returned by the memory |

## Verification
A read result is due `T_RCD+T_ASC+ACC` edges after the accepting edge, which is 5 with the defaults. The bench samples at the falling edge one cycle before that point and expects `rsp_valid` low, then samples at the next falling edge and expects the pulse and the stored word. The pin model samples every strobe once per cycle at the falling edge and does its checks on the cycle in which a strobe edge first shows. Strobe widths and precharge gaps are therefore measured in whole cycles against `T_RAS`, `T_RP` and `T_CSR`. The refresh budget is checked over one full window counted from the first refresh, with a 5000 kHz clock setting so that a refresh comes due every 78 cycles.

// File: rtl/dramc_pkg.sv
package dramc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROW,
        ST_COL,
        ST_ACCESS,
        ST_PRECHARGE,
        ST_CBR_CAS,
        ST_CBR_RAS,
        ST_CBR_PRE
    } dramc_state_e;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dramc_refresh.sv
module dramc_refresh #(
    parameter int INTERVAL = 781
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack,
    output logic pend
);
    localparam int TW = $clog2(INTERVAL + 1);

    logic [TW-1:0] tmr_q;
    logic          tick;

    assign tick = (tmr_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= TW'(INTERVAL - 1);
            pend  <= 1'b0;
        end else begin
            tmr_q <= tick ? TW'(INTERVAL - 1) : tmr_q - TW'(1);
            if (tick)
                pend <= 1'b1;
            else if (ack)
                pend <= 1'b0;
        end
    end

    // R7: each refresh is served before the next one falls due
    a_r7_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> !pend);

endmodule

// File: rtl/dramc_seq.sv
module dramc_seq
    import dramc_pkg::*;
#(
    parameter int T_RCD   = 2,
    parameter int T_ASC   = 1,
    parameter int ACC_LEN = 2,
    parameter int T_RAS   = 4,
    parameter int T_RP    = 3,
    parameter int T_CSR   = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic ref_pend,
    input  logic is_write,
    output logic req_ready,
    output logic ref_ack,
    output logic ras_n,
    output logic cas_n,
    output logic we_n,
    output logic oe_n,
    output logic dq_oe,
    output logic show_req,
    output logic show_col,
    output logic capture
);
    localparam int LEN_MAX = max2(max2(max2(T_RCD, T_ASC), max2(ACC_LEN, T_RAS)),
                                  max2(T_RP, T_CSR));
    localparam int CNT_W   = $clog2(LEN_MAX + 1);
    typedef logic [CNT_W-1:0] cnt_t;

    dramc_state_e state_q, state_d;
    cnt_t         cnt_q, cnt_d;
    logic         last;

    assign last = (cnt_q == '0);

    function automatic cnt_t load_of(input dramc_state_e s);
        cnt_t v;
        unique case (s)
            ST_IDLE:      v = '0;
            ST_ROW:       v = cnt_t'(T_RCD - 1);
            ST_COL:       v = cnt_t'(T_ASC - 1);
            ST_ACCESS:    v = cnt_t'(ACC_LEN - 1);
            ST_PRECHARGE: v = cnt_t'(T_RP - 1);
            ST_CBR_CAS:   v = cnt_t'(T_CSR - 1);
            ST_CBR_RAS:   v = cnt_t'(T_RAS - 1);
            ST_CBR_PRE:   v = cnt_t'(T_RP - 1);
            default:      v = '0;
        endcase
        return v;
    endfunction

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (ref_pend)       state_d = ST_CBR_CAS;
                else if (req_valid) state_d = ST_ROW;
            end
            ST_ROW:       if (last) state_d = ST_COL;
            ST_COL:       if (last) state_d = ST_ACCESS;
            ST_ACCESS:    if (last) state_d = ST_PRECHARGE;
            ST_PRECHARGE: if (last) state_d = ST_IDLE;
            ST_CBR_CAS:   if (last) state_d = ST_CBR_RAS;
            ST_CBR_RAS:   if (last) state_d = ST_CBR_PRE;
            ST_CBR_PRE:   if (last) state_d = ST_IDLE;
            default:                state_d = ST_IDLE;
        endcase
        if (state_d != state_q)
            cnt_d = load_of(state_d);
        else
            cnt_d = last ? cnt_q : cnt_q - cnt_t'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        ras_n    = 1'b1;
        cas_n    = 1'b1;
        we_n     = 1'b1;
        oe_n     = 1'b1;
        dq_oe    = 1'b0;
        show_req = 1'b0;
        show_col = 1'b0;
        capture  = 1'b0;
        unique case (state_q)
            ST_IDLE:   show_req = 1'b1;
            ST_ROW:    ras_n = 1'b0;
            ST_COL: begin
                ras_n    = 1'b0;
                show_col = 1'b1;
                we_n     = !is_write;
                dq_oe    = is_write;
            end
            ST_ACCESS: begin
                ras_n    = 1'b0;
                cas_n    = 1'b0;
                show_col = 1'b1;
                we_n     = !is_write;
                dq_oe    = is_write;
                oe_n     = is_write;
                capture  = last && !is_write;
            end
            ST_CBR_CAS: cas_n = 1'b0;
            ST_CBR_RAS: begin
                cas_n = 1'b0;
                ras_n = 1'b0;
            end
            default: ;
        endcase
    end

    assign req_ready = (state_q == ST_IDLE) && !ref_pend;
    assign ref_ack   = (state_q == ST_IDLE) && ref_pend;

    logic [15:0] ras_lo_run, ras_hi_run;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ras_lo_run <= '0;
            ras_hi_run <= 16'(T_RP);
        end else begin
            ras_lo_run <= ras_n ? '0 : ((&ras_lo_run) ? ras_lo_run : ras_lo_run + 16'd1);
            ras_hi_run <= !ras_n ? '0 : ((&ras_hi_run) ? ras_hi_run : ras_hi_run + 16'd1);
        end
    end

    a_r4_ras_min: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> ras_lo_run >= 16'(T_RAS));

    a_r5_precharge: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> ras_hi_run >= 16'(T_RP));

    a_r3_write_oe_high: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> oe_n);

    a_r6_cas_first: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n) && !cas_n) |-> $past(!cas_n));

endmodule

// File: rtl/dramc_dpath.sv
module dramc_dpath #(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic          req_we,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic          show_req,
    input  logic          show_col,
    input  logic          capture,
    input  logic [DW-1:0] dq_in,
    output logic          is_write,
    output logic [AW/2-1:0] pin_addr,
    output logic [DW-1:0] dq_out,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata
);
    localparam int PW = AW / 2;

    logic [PW-1:0] row_q, col_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_q     <= '0;
            col_q     <= '0;
            is_write  <= 1'b0;
            dq_out    <= '0;
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            if (accept) begin
                row_q    <= req_addr[AW-1:PW];
                col_q    <= req_addr[PW-1:0];
                is_write <= req_we;
                dq_out   <= req_wdata;
            end
            rsp_valid <= capture;
            if (capture)
                rsp_rdata <= dq_in;
        end
    end

    assign pin_addr = show_req ? req_addr[AW-1:PW] : (show_col ? col_q : row_q);

    a_r2_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    a_r1_col_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (show_col && $past(show_col)) |-> $stable(pin_addr));

endmodule

// File: rtl/dram_ctrl.sv
module dram_ctrl
    import dramc_pkg::*;
#(
    parameter int CLK_KHZ   = 50000,
    parameter int WINDOW_MS = 4,
    parameter int ROWS      = 256,
    parameter int T_RCD     = 2,
    parameter int T_ASC     = 1,
    parameter int T_CAC     = 2,
    parameter int T_CAA     = 3,
    parameter int T_RAC     = 4,
    parameter int T_RAS     = 4,
    parameter int T_RP      = 3,
    parameter int T_CSR     = 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic        req_we,
    input  logic [15:0] req_addr,
    input  logic [15:0] req_wdata,
    output logic        rsp_valid,
    output logic [15:0] rsp_rdata,
    output logic [7:0]  dram_addr,
    output logic        dram_ras_n,
    output logic        dram_cas_n,
    output logic        dram_we_n,
    output logic        dram_oe_n,
    output logic [15:0] dram_dq_out,
    output logic        dram_dq_oe,
    input  logic [15:0] dram_dq_in
);
    localparam int REF_INTERVAL = (CLK_KHZ * WINDOW_MS) / ROWS;
    localparam int ACC_LEN = max2(1, max2(max2(T_CAC, T_CAA - T_ASC),
                                          max2(T_RAC - T_RCD - T_ASC, T_RAS - T_RCD - T_ASC)));

    logic ref_pend, ref_ack, is_write, show_req, show_col, capture, accept;

    assign accept = req_valid && req_ready;

    dramc_refresh #(.INTERVAL(REF_INTERVAL)) u_refresh (
        .clk  (clk),
        .rst_n(rst_n),
        .ack  (ref_ack),
        .pend (ref_pend)
    );

    dramc_seq #(
        .T_RCD(T_RCD), .T_ASC(T_ASC), .ACC_LEN(ACC_LEN),
        .T_RAS(T_RAS), .T_RP(T_RP), .T_CSR(T_CSR)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .ref_pend (ref_pend),
        .is_write (is_write),
        .req_ready(req_ready),
        .ref_ack  (ref_ack),
        .ras_n    (dram_ras_n),
        .cas_n    (dram_cas_n),
        .we_n     (dram_we_n),
        .oe_n     (dram_oe_n),
        .dq_oe    (dram_dq_oe),
        .show_req (show_req),
        .show_col (show_col),
        .capture  (capture)
    );

    dramc_dpath #(.AW(16), .DW(16)) u_dpath (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .req_we   (req_we),
        .req_addr (req_addr),
        .req_wdata(req_wdata),
        .show_req (show_req),
        .show_col (show_col),
        .capture  (capture),
        .dq_in    (dram_dq_in),
        .is_write (is_write),
        .pin_addr (dram_addr),
        .dq_out   (dram_dq_out),
        .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata)
    );

    a_r8_busy_in_refresh: assert property (@(posedge clk) disable iff (!rst_n)
        (!dram_cas_n && dram_ras_n) |-> !req_ready);

    a_r6_refresh_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (!dram_cas_n && dram_ras_n) |-> (!dram_dq_oe && dram_oe_n && dram_we_n));

endmodule

// File: tb/dram_ctrl_tb.sv
module dram_ctrl_tb;
    localparam int CLK_KHZ = 5000;
    localparam int T_RCD = 2, T_ASC = 1, T_CAC = 2, T_CAA = 3, T_RAC = 4;
    localparam int T_RAS = 4, T_RP = 3, T_CSR = 1;
    localparam int WIN  = CLK_KHZ * 4;
    localparam int A1   = (T_CAC > T_CAA - T_ASC) ? T_CAC : T_CAA - T_ASC;
    localparam int A2   = (T_RAC > T_RAS) ? T_RAC - T_RCD - T_ASC : T_RAS - T_RCD - T_ASC;
    localparam int A3   = (A1 > A2) ? A1 : A2;
    localparam int ACC  = (A3 > 1) ? A3 : 1;
    localparam int LAT  = T_RCD + T_ASC + ACC;
    localparam int NOPS = 500;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        req_valid = 1'b0, req_we = 1'b0;
    logic [15:0] req_addr = '0, req_wdata = '0;
    logic        req_ready, rsp_valid;
    logic [15:0] rsp_rdata;
    logic [7:0]  dram_addr;
    logic        dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe;
    logic [15:0] dram_dq_out;
    logic [15:0] dram_dq_in = 16'hDEAD;

    int checks = 0, fails = 0, cyc = 0;
    bit done = 0;

    logic [15:0] dram_mem [logic [15:0]];
    logic [15:0] expect_mem [logic [15:0]];
    logic [15:0] cur_addr = '0, cur_data = '0;
    logic        cur_we = 1'b0;
    logic [7:0]  row_l = '0;
    logic        ras_q = 1'b1, cas_q = 1'b1;
    int ras_lo_run = 0, ras_hi_run = T_RP, cas_lo_run = 0;
    int first_ref = -1, ref_in_win = 0, ref_total = 0;

    dram_ctrl #(.CLK_KHZ(CLK_KHZ)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .dram_addr(dram_addr), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
        .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n),
        .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Pin model: samples once per cycle at the falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (ras_q && !dram_ras_n) begin
                chk(ras_hi_run >= T_RP, "R5 precharge", ras_hi_run, T_RP);
                if (!dram_cas_n) begin
                    chk(cas_lo_run >= T_CSR, "R6 cas lead", cas_lo_run, T_CSR);
                    chk(!dram_dq_oe && dram_oe_n && dram_we_n, "R6 refresh idle pins",
                        {dram_dq_oe, dram_oe_n, dram_we_n}, 3'b011);
                    chk(!req_ready, "R8 ready during refresh", req_ready, 0);
                    ref_total++;
                    if (first_ref < 0) first_ref = cyc;
                    if (cyc - first_ref < WIN) ref_in_win++;
                end else begin
                    row_l = dram_addr;
                    chk(dram_addr == cur_addr[15:8], "R1 row", dram_addr, cur_addr[15:8]);
                end
            end
            if (!ras_q && dram_ras_n)
                chk(ras_lo_run >= T_RAS, "R4 ras width", ras_lo_run, T_RAS);
            if (cas_q && !dram_cas_n) begin
                if (!dram_ras_n) begin
                    chk(dram_addr == cur_addr[7:0], "R1 column", dram_addr, cur_addr[7:0]);
                    if (cur_we) begin
                        chk(!dram_we_n && dram_dq_oe && dram_oe_n && dram_dq_out == cur_data,
                            "R3 write pins", dram_dq_out, cur_data);
                        dram_mem[{row_l, dram_addr}] = dram_dq_out;
                    end else begin
                        chk(dram_we_n, "R2 WE high on read", dram_we_n, 1);
                    end
                end else begin
                    chk(!req_ready, "R8 ready at refresh start", req_ready, 0);
                end
            end
            if (!dram_ras_n && !dram_cas_n && !dram_oe_n && dram_we_n) begin
                if (dram_mem.exists({row_l, dram_addr}))
                    dram_dq_in = dram_mem[{row_l, dram_addr}];
                else
                    dram_dq_in = 16'h0000;
            end else begin
                dram_dq_in = 16'hDEAD;
            end
            ras_lo_run = dram_ras_n ? 0 : ras_lo_run + 1;
            ras_hi_run = dram_ras_n ? ras_hi_run + 1 : 0;
            cas_lo_run = dram_cas_n ? 0 : cas_lo_run + 1;
            ras_q = dram_ras_n;
            cas_q = dram_cas_n;
        end
    end

    task automatic do_op(input bit we, input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        cur_addr = a; cur_we = we; cur_data = d;
        req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        if (we) begin
            expect_mem[a] = d;
        end else begin
            repeat (LAT - 1) @(negedge clk);
            chk(!rsp_valid, "R2 no early valid", rsp_valid, 0);
            @(negedge clk);
            chk(rsp_valid, "R2 valid on time", rsp_valid, 1);
            chk(rsp_rdata == expect_mem[a], "R2 read data", rsp_rdata, expect_mem[a]);
        end
    endtask

    function automatic logic [15:0] sweep_addr(input int i);
        return 16'(i * 2897 + 13);
    endfunction

    task automatic finish_run;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (300000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [15:0] corners [4];
        corners[0] = 16'h0000; corners[1] = 16'hFFFF;
        corners[2] = 16'h00FF; corners[3] = 16'hFF00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9 reset state
        chk(dram_ras_n && dram_cas_n, "R9 strobes high", {dram_ras_n, dram_cas_n}, 2'b11);
        chk(!dram_dq_oe && !rsp_valid, "R9 no drive/valid", {dram_dq_oe, rsp_valid}, 0);
        chk(req_ready, "R9 ready", req_ready, 1);
        for (int k = 0; k < 4; k++) do_op(1'b1, corners[k], ~corners[k] ^ 16'h1234);
        for (int i = 0; i < NOPS; i++) do_op(1'b1, sweep_addr(i), sweep_addr(i) ^ 16'(16'hA5C3 + i));
        for (int k = 0; k < 4; k++) do_op(1'b0, corners[k], 16'h0);
        for (int i = 0; i < NOPS; i++) do_op(1'b0, sweep_addr(i), 16'h0);
        // overwrite then read back the same word
        do_op(1'b1, 16'h5A5A, 16'h0F0F);
        do_op(1'b1, 16'h5A5A, 16'hF0F0);
        do_op(1'b0, 16'h5A5A, 16'h0);
        while (first_ref < 0 || cyc < first_ref + WIN + 200) @(negedge clk);
        // R7 refresh budget over one full window
        chk(ref_in_win >= 256, "R7 refreshes per window", ref_in_win, 256);
        done = 1;
        finish_run();
    end
endmodule